// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block produces the program counter for a small vector-shader instruction stream. The fetch stage hands it the decoded instruction found at the current PC. The sequencer then advances the PC, jumps, or enters a subroutine, an if/else region or a counted loop. A single hardware stack of region records backs every nested construct. Each record holds an end address, a return address, a loop-start address, an 8-bit repeat count and an 8-bit loop increment. Condition evaluation is outside the block and arrives as one bit. Boolean and integer uniform banks are wired in as flat vectors.

At most one action happens per clock. Before an instruction is accepted, the top record's end address is compared with the PC. On a match, that cycle is spent leaving or repeating the region, and `instReady` stays low. Otherwise, a valid instruction is consumed. The loop address register and the end-of-program flag are visible at the ports. A start pulse loads the PC from `startOffset`, empties the stack and begins sequencing.

Top module: `flow_sequencer`

## Requirements
- R1: After reset, `pc`, `loopAddr`, `endFlag`, `stackOverflow` and `instReady` are all zero, and nothing is sequenced until `start` is pulsed.
- R2: A `start` pulse loads `pc` with `startOffset`, empties the stack, clears `endFlag` and begins sequencing. Start takes priority over every other action in that cycle.
- R3: Opcode encoding on `instOp`:
  - 0 = no-op, 1 = end, 2 = condition jump, 3 = uniform jump, 4 = call, 5 = uniform call, 6 = condition call, 7 = uniform if, 8 = condition if, 9 = loop.
  - Codes 10 to 15 are ordinary non-flow instructions.
  - A no-op or a non-flow instruction advances `pc` by one.
  - While `instValid` is low, no instruction is consumed and `pc` holds (unless an end-address match is pending).
- R4: Jumps:
  - A condition jump sets `pc` to `instDest` when `condTrue` is 1, and otherwise advances by one.
  - A uniform jump is taken when `boolUniforms[instBoolIdx]` equals the inverse of `instCount[0]`.
- R5: Calls:
  - A call always enters its subroutine.
  - A uniform call enters only if `boolUniforms[instBoolIdx]` is 1.
  - A condition call enters only if `condTrue` is 1.
  - Entering sets `pc` to `instDest` and pushes {end `instDest+instCount`, return `pc+1`, start `instDest`, repeat 0, increment 0}.
  - A call that is not entered advances `pc` by one.
- R6: End of region:
  - When the stack is non-empty and `pc` equals the top record's end address, the top record's increment is added to `loopAddr`.
  - If its repeat count is zero, the record is popped and `pc` takes the return address.
  - `instReady` is low in that cycle, and no instruction is consumed.
- R7: In the same situation with a non-zero repeat count, the count is decremented, `pc` takes the record's start address, and the record stays on the stack.
- R8: If regions, for an if at `pc` with destination D and count N:
  - A true selector (uniform bit for opcode 7, `condTrue` for opcode 8) enters `pc+1` with end address D.
  - A false selector enters D with end address D+N.
  - Both cases return to D+N.
- R9: A loop reads integer uniform `intUniforms[instIntIdx]`, whose fields are x = bits 7:0, y = bits 15:8 and z = bits 23:16. It:
  - loads `loopAddr` with y;
  - sets `pc` to `pc+1`;
  - pushes {end D+2, return D+1, start `pc+1`, repeat x, increment z}.
- R10: The stack holds DEPTH records (16 by default). An entering call, if or loop that meets a full stack does the following:
  - it sets `stackOverflow`, which stays set until reset;
  - it pushes nothing and leaves `loopAddr` unchanged;
  - it advances `pc` by one.
- R11: An end instruction raises `endFlag` and stops sequencing. Afterwards `pc` holds and `instReady` stays low until the next `start`.
- R12: Only one record is retired per cycle. When several nested records share an end address, they unwind on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin sequencing at `startOffset` |
| startOffset | input | PC_W | Program entry address |
| instValid | input | 1 | Decoded instruction for current `pc` is present |
| instReady | output | 1 | Instruction will be consumed this cycle if valid |
| instOp | input | 4 | Opcode (see R3) |
| instDest | input | PC_W | Destination offset field |
| instCount | input | PC_W | Instruction count field |
| instBoolIdx | input | log2(NB) | Boolean uniform selector |
| instIntIdx | input | log2(NI) | Integer uniform selector |
| condTrue | input | 1 | Externally evaluated condition result |
| boolUniforms | input | NB | Boolean uniform bank |
| intUniforms | input | NI*3*8 | Integer uniform bank, x/y/z bytes per entry |
| pc | output | PC_W | Program counter |
| loopAddr | output | LA_W | Loop address register |
| endFlag | output | 1 | Program has ended |
| stackOverflow | output | 1 | Sticky stack-overflow error |

## Verification
The end-of-region check and the consumption of an instruction can both fall due in the same cycle: the PC reaches a record's end address while the fetch stage is offering the instruction stored there. The tests place regions whose end address holds a real instruction, and nest a call whose return address is itself the end of the enclosing region. In both cases `instReady` must stay low while the record is retired, and the PC trace must show one unwind per cycle before that address is executed. A cycle-stepped model of the requirements, kept inside the bench, judges every cycle's `pc`, `instReady`, `loopAddr`, `endFlag` and `stackOverflow`. This includes runs where `instValid` is dropped periodically, so that stalls coincide with unwinds.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_END   = 4'd1,
    OP_JMPC  = 4'd2,
    OP_JMPU  = 4'd3,
    OP_CALL  = 4'd4,
    OP_CALLU = 4'd5,
    OP_CALLC = 4'd6,
    OP_IFU   = 4'd7,
    OP_IFC   = 4'd8,
    OP_LOOP  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_INC,
    PC_DEST,
    PC_PUSH,
    PC_RET,
    PC_LOOP,
    PC_START
  } pc_sel_e;

  typedef enum logic [1:0] {
    RK_CALL,
    RK_IFT,
    RK_IFF,
    RK_LOOP
  } rec_kind_e;

  typedef struct packed {
    pc_sel_e   pcSel;
    logic      push;
    rec_kind_e kind;
    logic      pop;
    logic      decRep;
    logic      bumpLoop;
    logic      loadLoop;
    logic      clear;
  } seq_strobe_t;

endpackage

// File: rtl/flow_seq_ctrl.sv
module flow_seq_ctrl
  import flow_seq_pkg::*;
#(
  parameter int NB     = 16,
  parameter int BIDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              instValid,
  input  logic [3:0]        instOp,
  input  logic              instCountLsb,
  input  logic [BIDX_W-1:0] instBoolIdx,
  input  logic              condTrue,
  input  logic [NB-1:0]     boolUniforms,
  input  logic              stackEmpty,
  input  logic              stackFull,
  input  logic              topMatch,
  input  logic              topRepZero,
  output seq_strobe_t       strobe,
  output logic              instReady,
  output logic              endFlag,
  output logic              ovfFlag
);

  logic running;
  logic unwind;
  logic exec;
  logic boolSel;
  logic doCall;
  logic setEnd;
  logic setOvf;
  rec_kind_e callKind;

  always_comb begin
    unwind    = running && !stackEmpty && topMatch;
    instReady = running && !unwind;
    exec      = instReady && instValid;
    boolSel   = boolUniforms[instBoolIdx];
    strobe       = '0;
    strobe.pcSel = PC_HOLD;
    strobe.kind  = RK_CALL;
    doCall   = 1'b0;
    callKind = RK_CALL;
    setEnd   = 1'b0;
    setOvf   = 1'b0;
    if (start) begin
      strobe.pcSel = PC_START;
      strobe.clear = 1'b1;
    end else if (unwind) begin
      strobe.bumpLoop = 1'b1;
      if (topRepZero) begin
        strobe.pop   = 1'b1;
        strobe.pcSel = PC_RET;
      end else begin
        strobe.decRep = 1'b1;
        strobe.pcSel  = PC_LOOP;
      end
    end else if (exec) begin
      strobe.pcSel = PC_INC;
      case (op_e'(instOp))
        OP_END: begin
          setEnd       = 1'b1;
          strobe.pcSel = PC_HOLD;
        end
        OP_JMPC:  if (condTrue) strobe.pcSel = PC_DEST;
        OP_JMPU:  if (boolSel == !instCountLsb) strobe.pcSel = PC_DEST;
        OP_CALL:  doCall = 1'b1;
        OP_CALLU: doCall = boolSel;
        OP_CALLC: doCall = condTrue;
        OP_IFU: begin
          doCall   = 1'b1;
          callKind = boolSel ? RK_IFT : RK_IFF;
        end
        OP_IFC: begin
          doCall   = 1'b1;
          callKind = condTrue ? RK_IFT : RK_IFF;
        end
        OP_LOOP: begin
          doCall   = 1'b1;
          callKind = RK_LOOP;
        end
        default: ;
      endcase
      if (doCall) begin
        if (stackFull) begin
          setOvf = 1'b1;
        end else begin
          strobe.push     = 1'b1;
          strobe.kind     = callKind;
          strobe.pcSel    = PC_PUSH;
          strobe.loadLoop = (callKind == RK_LOOP);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      endFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (start) begin
        running <= 1'b1;
        endFlag <= 1'b0;
      end else if (setEnd) begin
        running <= 1'b0;
        endFlag <= 1'b1;
      end
      if (setOvf) ovfFlag <= 1'b1;
    end
  end

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |=> ovfFlag);

  p_end_stops_r11: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !start) |=> !instReady);

  p_one_action_r12: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.push, strobe.pop, strobe.decRep}) <= 1);

endmodule

// File: rtl/flow_seq_dp.sv
module flow_seq_dp
  import flow_seq_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int DEPTH  = 16,
  parameter int LA_W   = 8,
  parameter int UB_W   = 8,
  parameter int NI     = 4,
  parameter int IIDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           strobe,
  input  logic [PC_W-1:0]       startOffset,
  input  logic [PC_W-1:0]       instDest,
  input  logic [PC_W-1:0]       instCount,
  input  logic [IIDX_W-1:0]     instIntIdx,
  input  logic [NI*3*UB_W-1:0]  intUniforms,
  output logic [PC_W-1:0]       pc,
  output logic [LA_W-1:0]       loopAddr,
  output logic                  stackEmpty,
  output logic                  stackFull,
  output logic                  topMatch,
  output logic                  topRepZero
);

  localparam int DEP_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IU_W  = 3 * UB_W;

  logic [DEP_W-1:0] depthQ;
  logic [PC_W-1:0]  recEnd   [DEPTH];
  logic [PC_W-1:0]  recRet   [DEPTH];
  logic [PC_W-1:0]  recStart [DEPTH];
  logic [UB_W-1:0]  recRep   [DEPTH];
  logic [UB_W-1:0]  recInc   [DEPTH];

  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] pushIdx;
  logic [PC_W-1:0]  pcPlus1;
  logic [PC_W-1:0]  tgtV, endV, retV, pcNext;
  logic [UB_W-1:0]  repV, incV;
  logic [UB_W-1:0]  uX, uY, uZ;
  logic [PC_W-1:0]  topRet, topStart;

  assign uX = intUniforms[instIntIdx*IU_W +: UB_W];
  assign uY = intUniforms[instIntIdx*IU_W + UB_W +: UB_W];
  assign uZ = intUniforms[instIntIdx*IU_W + 2*UB_W +: UB_W];

  assign topIdx     = IDX_W'(depthQ - DEP_W'(1));
  assign pushIdx    = IDX_W'(depthQ);
  assign stackEmpty = (depthQ == '0);
  assign stackFull  = (depthQ == DEP_W'(DEPTH));
  assign topMatch   = (pc == recEnd[topIdx]);
  assign topRepZero = (recRep[topIdx] == '0);
  assign topRet     = recRet[topIdx];
  assign topStart   = recStart[topIdx];
  assign pcPlus1    = pc + PC_W'(1);

  always_comb begin
    repV = '0;
    incV = '0;
    case (strobe.kind)
      RK_IFT: begin
        tgtV = pcPlus1;
        endV = pcPlus1 + (instDest - pc - PC_W'(1));
        retV = instDest + instCount;
      end
      RK_IFF: begin
        tgtV = instDest;
        endV = instDest + instCount;
        retV = instDest + instCount;
      end
      RK_LOOP: begin
        tgtV = pcPlus1;
        endV = pcPlus1 + (instDest - pc + PC_W'(1));
        retV = instDest + PC_W'(1);
        repV = uX;
        incV = uZ;
      end
      default: begin
        tgtV = instDest;
        endV = instDest + instCount;
        retV = pcPlus1;
      end
    endcase
  end

  always_comb begin
    case (strobe.pcSel)
      PC_INC:   pcNext = pcPlus1;
      PC_DEST:  pcNext = instDest;
      PC_PUSH:  pcNext = tgtV;
      PC_RET:   pcNext = topRet;
      PC_LOOP:  pcNext = topStart;
      PC_START: pcNext = startOffset;
      default:  pcNext = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= '0;
      loopAddr <= '0;
      depthQ   <= '0;
    end else begin
      pc <= pcNext;
      if (strobe.loadLoop)
        loopAddr <= LA_W'(uY);
      else if (strobe.bumpLoop)
        loopAddr <= loopAddr + LA_W'(recInc[topIdx]);
      if (strobe.clear)
        depthQ <= '0;
      else if (strobe.push)
        depthQ <= depthQ + DEP_W'(1);
      else if (strobe.pop)
        depthQ <= depthQ - DEP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < DEPTH; g++) begin
      if (strobe.push && !strobe.clear && pushIdx == IDX_W'(g)) begin
        recEnd[g]   <= endV;
        recRet[g]   <= retV;
        recStart[g] <= tgtV;
        recRep[g]   <= repV;
        recInc[g]   <= incV;
      end else if (strobe.decRep && topIdx == IDX_W'(g)) begin
        recRep[g] <= recRep[g] - UB_W'(1);
      end
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pcSel == PC_INC) |=> pc == $past(pc) + PC_W'(1));

  p_push_depth_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.clear) |=> depthQ == $past(depthQ) + DEP_W'(1));

  p_pop_ret_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> (pc == $past(topRet)) && (depthQ == $past(depthQ) - DEP_W'(1)));

  p_repeat_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decRep |=> (pc == $past(topStart)) && $stable(depthQ));

  p_loop_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLoop |=> loopAddr == LA_W'($past(uY)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= DEP_W'(DEPTH));

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
  import flow_seq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int DEPTH = 16,
  parameter int NB    = 16,
  parameter int NI    = 4,
  parameter int UB_W  = 8,
  parameter int LA_W  = 8,
  localparam int BIDX_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int IIDX_W = (NI > 1) ? $clog2(NI) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [PC_W-1:0]       startOffset,
  input  logic                  instValid,
  output logic                  instReady,
  input  logic [3:0]            instOp,
  input  logic [PC_W-1:0]       instDest,
  input  logic [PC_W-1:0]       instCount,
  input  logic [BIDX_W-1:0]     instBoolIdx,
  input  logic [IIDX_W-1:0]     instIntIdx,
  input  logic                  condTrue,
  input  logic [NB-1:0]         boolUniforms,
  input  logic [NI*3*UB_W-1:0]  intUniforms,
  output logic [PC_W-1:0]       pc,
  output logic [LA_W-1:0]       loopAddr,
  output logic                  endFlag,
  output logic                  stackOverflow
);

  seq_strobe_t strobe;
  logic stackEmpty, stackFull, topMatch, topRepZero;

  flow_seq_ctrl #(.NB(NB), .BIDX_W(BIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .instValid(instValid),
    .instOp(instOp), .instCountLsb(instCount[0]), .instBoolIdx(instBoolIdx),
    .condTrue(condTrue), .boolUniforms(boolUniforms),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .topMatch(topMatch),
    .topRepZero(topRepZero), .strobe(strobe), .instReady(instReady),
    .endFlag(endFlag), .ovfFlag(stackOverflow)
  );

  flow_seq_dp #(.PC_W(PC_W), .DEPTH(DEPTH), .LA_W(LA_W), .UB_W(UB_W),
                .NI(NI), .IIDX_W(IIDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startOffset(startOffset),
    .instDest(instDest), .instCount(instCount), .instIntIdx(instIntIdx),
    .intUniforms(intUniforms), .pc(pc), .loopAddr(loopAddr),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .topMatch(topMatch),
    .topRepZero(topRepZero)
  );

  p_end_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !start) |=> $stable(pc));

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (pc == $past(startOffset)) && !endFlag);

endmodule

// File: tb/test_flow_sequencer.sv
module test_flow_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] startOffset = '0;
  logic        instValid = 1'b0;
  logic        instReady;
  logic [3:0]  instOp = '0;
  logic [11:0] instDest = '0;
  logic [11:0] instCount = '0;
  logic [3:0]  instBoolIdx = '0;
  logic [1:0]  instIntIdx = '0;
  logic        condTrue = 1'b0;
  logic [15:0] boolU = '0;
  logic [95:0] intU = '0;
  logic [11:0] pc;
  logic [7:0]  loopAddr;
  logic        endFlag;
  logic        stackOverflow;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  flow_sequencer i_flow_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .startOffset(startOffset),
    .instValid(instValid), .instReady(instReady), .instOp(instOp),
    .instDest(instDest), .instCount(instCount), .instBoolIdx(instBoolIdx),
    .instIntIdx(instIntIdx), .condTrue(condTrue), .boolUniforms(boolU),
    .intUniforms(intU), .pc(pc), .loopAddr(loopAddr), .endFlag(endFlag),
    .stackOverflow(stackOverflow)
  );

  // program image
  logic [3:0]  pOp  [64];
  logic [11:0] pDest[64];
  logic [11:0] pCnt [64];
  logic [3:0]  pB   [64];
  logic [1:0]  pI   [64];
  logic        pC   [64];

  // requirement model
  logic [11:0] mPc = '0;
  logic [7:0]  mLoop = '0;
  int          mDepth = 0;
  logic        mRun = 1'b0, mEnd = 1'b0, mOvf = 1'b0;
  logic [11:0] mE[16], mR[16], mS[16];
  logic [7:0]  mRep[16], mInc[16];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 64; i++) begin
      pOp[i] = 4'd0; pDest[i] = '0; pCnt[i] = '0; pB[i] = '0; pI[i] = '0; pC[i] = 1'b0;
    end
  endtask

  task automatic setI(input int a, input int op, input int d, input int n,
                      input int b, input int u, input bit c);
    pOp[a] = 4'(op); pDest[a] = 12'(d); pCnt[a] = 12'(n);
    pB[a] = 4'(b); pI[a] = 2'(u); pC[a] = c;
  endtask

  task automatic mCall(input logic [11:0] o, input logic [11:0] e, input logic [11:0] r,
                       input logic [7:0] rep, input logic [7:0] inc);
    if (mDepth == 16) begin
      mOvf = 1'b1;
      mPc = mPc + 12'd1;
    end else begin
      mE[mDepth] = e; mR[mDepth] = r; mS[mDepth] = o;
      mRep[mDepth] = rep; mInc[mDepth] = inc;
      mDepth++;
      mPc = o;
    end
  endtask

  task automatic mStep(input bit v);
    logic [5:0] a;
    logic [23:0] u;
    int t;
    a = mPc[5:0];
    if (!mRun) return;
    if (mDepth > 0 && mPc == mE[mDepth-1]) begin
      t = mDepth - 1;
      mLoop = mLoop + mInc[t];
      if (mRep[t] == 8'd0) begin
        mPc = mR[t];
        mDepth--;
      end else begin
        mRep[t] = mRep[t] - 8'd1;
        mPc = mS[t];
      end
    end else if (v) begin
      case (pOp[a])
        4'd1: begin mRun = 1'b0; mEnd = 1'b1; end
        4'd2: mPc = pC[a] ? pDest[a] : mPc + 12'd1;
        4'd3: mPc = (boolU[pB[a]] == !pCnt[a][0]) ? pDest[a] : mPc + 12'd1;
        4'd4: mCall(pDest[a], pDest[a] + pCnt[a], mPc + 12'd1, 8'd0, 8'd0);
        4'd5: if (boolU[pB[a]]) mCall(pDest[a], pDest[a] + pCnt[a], mPc + 12'd1, 8'd0, 8'd0);
              else mPc = mPc + 12'd1;
        4'd6: if (pC[a]) mCall(pDest[a], pDest[a] + pCnt[a], mPc + 12'd1, 8'd0, 8'd0);
              else mPc = mPc + 12'd1;
        4'd7, 4'd8: begin
          if ((pOp[a] == 4'd7) ? boolU[pB[a]] : pC[a])
            mCall(mPc + 12'd1, pDest[a], pDest[a] + pCnt[a], 8'd0, 8'd0);
          else
            mCall(pDest[a], pDest[a] + pCnt[a], pDest[a] + pCnt[a], 8'd0, 8'd0);
        end
        4'd9: begin
          u = intU[pI[a]*24 +: 24];
          if (mDepth < 16) mLoop = u[15:8];
          mCall(mPc + 12'd1, pDest[a] + 12'd2, pDest[a] + 12'd1, u[7:0], u[23:16]);
        end
        default: mPc = mPc + 12'd1;
      endcase
    end
  endtask

  task automatic compareState(input string tag);
    bit expReady;
    expReady = mRun && !(mDepth > 0 && mPc == mE[mDepth-1]);
    checks++;
    if (pc !== mPc || instReady !== expReady || endFlag !== mEnd ||
        loopAddr !== mLoop || stackOverflow !== mOvf) begin
      errors++;
      $display("FAIL %s: pc=%0d ready=%b end=%b loop=%0d ovf=%b expected pc=%0d ready=%b end=%b loop=%0d ovf=%b",
               tag, pc, instReady, endFlag, loopAddr, stackOverflow,
               mPc, expReady, mEnd, mLoop, mOvf);
    end
  endtask

  // R2: start pulse, then cycle-by-cycle comparison against the model
  task automatic runProg(input string tag, input int startAddr, input int stallEvery);
    int extra;
    bit v;
    extra = 0;
    @(negedge clk);
    start = 1'b1; startOffset = 12'(startAddr); instValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    mPc = 12'(startAddr); mDepth = 0; mRun = 1'b1; mEnd = 1'b0;
    for (int c = 0; c < 2000 && extra < 3; c++) begin
      compareState(tag);
      v = (stallEvery == 0) || ((c % stallEvery) != stallEvery - 1);
      instOp = pOp[pc[5:0]]; instDest = pDest[pc[5:0]]; instCount = pCnt[pc[5:0]];
      instBoolIdx = pB[pc[5:0]]; instIntIdx = pI[pc[5:0]]; condTrue = pC[pc[5:0]];
      instValid = v;
      mStep(v);
      @(negedge clk);
      if (mEnd) extra++;
    end
    compareState(tag);
    check(endFlag === 1'b1, {tag, " R11 program reached end"}, int'(endFlag), 1);
    instValid = 1'b0;
  endtask

  task automatic testReset();
    check(pc === 12'd0, "R1 pc", int'(pc), 0);
    check(loopAddr === 8'd0, "R1 loopAddr", int'(loopAddr), 0);
    check(endFlag === 1'b0, "R1 endFlag", int'(endFlag), 0);
    check(stackOverflow === 1'b0, "R1 overflow", int'(stackOverflow), 0);
    check(instReady === 1'b0, "R1 ready", int'(instReady), 0);
  endtask

  task automatic testJumps();
    clearProg();
    boolU = 16'h0002;
    setI(0, 12, 0, 0, 0, 0, 0);
    setI(1, 2, 10, 0, 0, 0, 0);
    setI(2, 2, 5, 0, 0, 0, 1);
    setI(5, 3, 8, 0, 1, 0, 0);
    setI(8, 3, 12, 1, 2, 0, 0);
    setI(12, 3, 30, 1, 1, 0, 0);
    setI(13, 1, 0, 0, 0, 0, 0);
    runProg("R3 R4 jumps with stalls", 0, 3);
  endtask

  task automatic testCalls();
    clearProg();
    boolU = 16'h0002;
    setI(0, 4, 20, 3, 0, 0, 0);
    setI(1, 5, 30, 2, 3, 0, 0);
    setI(2, 6, 30, 2, 0, 0, 1);
    setI(3, 5, 50, 1, 1, 0, 0);
    setI(4, 1, 0, 0, 0, 0, 0);
    setI(21, 6, 40, 2, 0, 0, 0);
    setI(22, 12, 0, 0, 0, 0, 0);
    setI(23, 12, 0, 0, 0, 0, 0);
    setI(31, 4, 40, 2, 0, 0, 0);
    setI(32, 12, 0, 0, 0, 0, 0);
    setI(42, 12, 0, 0, 0, 0, 0);
    setI(51, 12, 0, 0, 0, 0, 0);
    runProg("R5 R6 R12 calls and shared end", 0, 0);
  endtask

  task automatic testIf(input int stall);
    clearProg();
    boolU = 16'h0002;
    setI(0, 7, 4, 2, 1, 0, 0);
    setI(4, 12, 0, 0, 0, 0, 0);
    setI(6, 8, 9, 2, 0, 0, 0);
    setI(7, 1, 0, 0, 0, 0, 0);
    setI(11, 1, 0, 0, 0, 0, 0);
    runProg("R8 if regions", 0, stall);
  endtask

  task automatic testLoops();
    int b;
    b = 10;
    clearProg();
    intU = '0;
    intU[23:0]  = {8'd3, 8'd5, 8'd2};
    intU[47:24] = {8'd1, 8'd40, 8'd1};
    setI(b + 0, 9, b + 4, 0, 0, 0, 0);
    setI(b + 2, 9, b + 3, 0, 0, 1, 0);
    setI(b + 6, 1, 0, 0, 0, 0, 0);
    runProg("R2 R7 R9 nested loops", b, 4);
  endtask

  task automatic testOverflow();
    logic [11:0] held;
    clearProg();
    setI(0, 4, 0, 5, 0, 0, 0);
    setI(1, 1, 0, 0, 0, 0, 0);
    runProg("R10 overflow", 0, 0);
    check(stackOverflow === 1'b1, "R10 overflow flag set", int'(stackOverflow), 1);
    check(pc === 12'd1, "R10 dropped push advances pc", int'(pc), 1);
    held = pc;
    repeat (4) @(negedge clk);
    check(pc === held, "R11 pc holds after end", int'(pc), int'(held));
    check(instReady === 1'b0, "R11 ready low after end", int'(instReady), 0);
    testIf(0);
    check(stackOverflow === 1'b1, "R10 overflow sticky across start", int'(stackOverflow), 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearProg();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testJumps();
    testCalls();
    testIf(2);
    testLoops();
    testOverflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule